// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block answers a three-wire serial memory bus (select, clock, data in, data out) from a small internal byte array of 1 Kbit. A host raises the select line and then clocks in a frame. The frame opens with a start bit. A two-bit command follows, then an address, and for a write the data word. The block executes the command once the last bit of the frame is in. Reads shift a word back out on the data output. Writes and erases start a self-timed programming period. During that period the data output can report a ready/busy flag.

A static strap picks the word size. With the strap high the array looks like 64 words of 16 bits. With it low it looks like 128 bytes. Both views share the same storage. All serial inputs are synchronised into the system clock, and the block acts on the rising edges of the serial clock it detects there. The programming period is counted in system clocks, so it does not need the serial clock.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While the select input is low, the frame logic is held idle, serial clock edges have no effect, and the data output enable is low. Dropping select part-way through a frame abandons that frame with no change to memory.
- R2: With select high and no frame in progress, clock edges that sample a 0 on the data input change nothing. The first 1 sampled is the start bit.
- R3: After the start bit the block takes a 2-bit command and then an address: 6 bits in 16-bit mode, 7 bits in 8-bit mode, both MSB first. The commands are 10 read, 01 write, 11 erase and 00 extended. In the extended command the two top address bits select the action: 11 enables writes and 00 disables them.
- R4: A read drives the output enable high with a 0 dummy bit on the clock edge that samples the last address bit. Each following rising edge then launches one data bit, MSB first. The edge after the last data bit releases the output.
- R5: A write takes 16 or 8 data bits, MSB first, and stores them only if writes are enabled. Writes are disabled after reset. A rejected write starts no busy period.
- R6: An erase sets the addressed word (16-bit mode) or byte (8-bit mode) to all ones, and only when writes are enabled.
- R7: A programming period lasts BUSY_CYCLES system clocks. It completes even if select goes low, and it needs no serial clock. Start bits seen during it are ignored.
- R8: If select rises from low while a programming period runs, the output is enabled and drives 0 while busy and 1 once ready. This lasts until a start bit or until select goes low. If select stays high through the whole period, the output stays disabled.
- R9: Once a command has executed, further clock edges and data bits are ignored until select goes low.
- R10: In 16-bit mode, word w is made of byte 2w (upper half) and byte 2w+1 (lower half) of the 8-bit view.
- R11: After reset the output enable is low, no period is busy, and writes are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word size strap: 1 = 16-bit, 0 = 8-bit |
| do_o | output | 1 | Serial data out / ready-busy flag |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The bench first sends clock edges with data held low ahead of the start bit. A design that takes the first edge as a start bit would misread the whole frame. It also sends a complete write frame during a programming period; a design that accepts it would corrupt a word that must stay unchanged. A frame cut short by select and a period run with select held low check that a write is abandoned in the first case and completed in the second. The dummy bit, the release of the output after the last read bit, and the byte order shared by the 16-bit and 8-bit views each catch off-by-one and swapped-half faults, because the bench compares whole read words against its own byte model.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WIDE_W   = 16;
  localparam int NARROW_W = 8;
  localparam int CNT_W    = $clog2(WIDE_W + 1);

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  localparam logic [1:0] EXT_WEN_ON  = 2'b11;
  localparam logic [1:0] EXT_WEN_OFF = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_DONE
  } mw_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (start_i)       cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int BYTE_AW = 7
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic               org_i,
  input  logic [BYTE_AW-1:0] addr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o
);
  localparam int NBYTES = 2 ** BYTE_AW;
  logic [7:0] mem [NBYTES];
  logic [BYTE_AW-1:0] hi_a, lo_a;

  assign hi_a = {addr_i[BYTE_AW-1:1], 1'b0};
  assign lo_a = {addr_i[BYTE_AW-1:1], 1'b1};

  // non-volatile cells: no reset
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (org_i) begin
        mem[hi_a] <= wdata_i[15:8];
        mem[lo_a] <= wdata_i[7:0];
      end else begin
        mem[addr_i] <= wdata_i[7:0];
      end
    end
  end

  assign rdata_o = org_i ? {mem[hi_a], mem[lo_a]} : {mem[addr_i], 8'h00};
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl import mw_pkg::*; #(
  parameter int WORD_AW = 6,
  parameter int BYTE_AW = WORD_AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               sclk_rise_i,
  input  logic               di_i,
  input  logic               org_i,
  input  logic               busy_i,
  input  logic [15:0]        rdata_i,
  output logic               prog_o,
  output logic [BYTE_AW-1:0] addr_o,
  output logic [15:0]        wdata_o,
  output logic               wen_o,
  output logic               do_o,
  output logic               do_oe_o
);
  mw_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         op;
  logic [BYTE_AW-1:0] adr_sh, addr_q;
  logic [15:0]        wsh, rsh;
  logic               rd_ld, do_q, rd_oe, stat_show, cs_q, wen, erase, prog;

  logic [BYTE_AW-1:0] addr_full, byte_base;
  logic [1:0]         ext;
  logic [CNT_W-1:0]   alen_m1, dlen, dlen_m1;

  assign addr_full = {adr_sh[BYTE_AW-2:0], di_i};
  assign byte_base = org_i ? {addr_full[WORD_AW-1:0], 1'b0} : addr_full;
  assign ext       = org_i ? addr_full[WORD_AW-1 -: 2] : addr_full[BYTE_AW-1 -: 2];
  assign alen_m1   = org_i ? CNT_W'(WORD_AW - 1) : CNT_W'(BYTE_AW - 1);
  assign dlen      = org_i ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
  assign dlen_m1   = dlen - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; op <= '0; adr_sh <= '0; addr_q <= '0;
      wsh <= '0; rsh <= '0; rd_ld <= 1'b0; do_q <= 1'b0; rd_oe <= 1'b0;
      stat_show <= 1'b0; cs_q <= 1'b0; wen <= 1'b0; erase <= 1'b0; prog <= 1'b0;
    end else begin
      prog <= 1'b0;
      cs_q <= cs_i;
      if (!cs_i) begin
        st <= ST_IDLE; cnt <= '0; rd_oe <= 1'b0; rd_ld <= 1'b0; stat_show <= 1'b0;
      end else begin
        if (!cs_q && busy_i) stat_show <= 1'b1;
        if (rd_ld) begin
          rsh   <= rdata_i;
          rd_ld <= 1'b0;
        end
        if (sclk_rise_i) begin
          unique case (st)
            ST_IDLE: if (di_i && !busy_i) begin
              st <= ST_OPC; cnt <= '0; stat_show <= 1'b0;
            end
            ST_OPC: begin
              op <= {op[0], di_i};
              if (cnt == CNT_W'(1)) begin st <= ST_ADR; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            ST_ADR: begin
              adr_sh <= addr_full;
              if (cnt == alen_m1) begin
                cnt    <= '0;
                addr_q <= byte_base;
                unique case (op)
                  OP_READ: begin
                    st <= ST_RD; do_q <= 1'b0; rd_oe <= 1'b1; rd_ld <= 1'b1;
                  end
                  OP_WRITE: st <= ST_DAT;
                  OP_ERASE: begin
                    st <= ST_DONE;
                    if (wen) begin prog <= 1'b1; erase <= 1'b1; end
                  end
                  default: begin
                    st <= ST_DONE;
                    if (ext == EXT_WEN_ON)       wen <= 1'b1;
                    else if (ext == EXT_WEN_OFF) wen <= 1'b0;
                  end
                endcase
              end else cnt <= cnt + 1'b1;
            end
            ST_DAT: begin
              wsh <= {wsh[14:0], di_i};
              if (cnt == dlen_m1) begin
                st <= ST_DONE;
                if (wen) begin prog <= 1'b1; erase <= 1'b0; end
              end else cnt <= cnt + 1'b1;
            end
            ST_RD: begin
              if (cnt == dlen) begin
                st <= ST_DONE; rd_oe <= 1'b0;
              end else begin
                do_q <= rsh[15];
                rsh  <= {rsh[14:0], 1'b0};
                cnt  <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign prog_o  = prog;
  assign addr_o  = addr_q;
  assign wdata_o = erase ? '1 : wsh;
  assign wen_o   = wen;
  assign do_oe_o = rd_oe | stat_show;
  assign do_o    = stat_show ? ~busy_i : do_q;
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int WORD_AW     = 6,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int BYTE_AW = WORD_AW + 1;

  logic [2:0]         sync_q;
  logic               cs_s, sclk_s, di_s, sclk_d, sclk_rise;
  logic               busy, prog, wen;
  logic [BYTE_AW-1:0] addr;
  logic [15:0]        wdata, rdata;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i({cs_i, sclk_i, di_i}), .q_o(sync_q)
  );
  assign {cs_s, sclk_s, di_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_d;

  mw_ctrl #(.WORD_AW(WORD_AW), .BYTE_AW(BYTE_AW)) i_ctrl (
    .clk_i, .rst_ni, .cs_i(cs_s), .sclk_rise_i(sclk_rise), .di_i(di_s),
    .org_i, .busy_i(busy), .rdata_i(rdata), .prog_o(prog), .addr_o(addr),
    .wdata_o(wdata), .wen_o(wen), .do_o, .do_oe_o
  );

  mw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
    .clk_i, .rst_ni, .start_i(prog), .busy_o(busy)
  );

  mw_array #(.BYTE_AW(BYTE_AW)) i_array (
    .clk_i, .we_i(prog), .org_i, .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic busy,
  input logic prog,
  input logic wen,
  input logic do_o,
  input logic do_oe_o
);
  AST_HIZ_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o); // R1
  AST_BUSY_FLAG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && do_oe_o) |-> !do_o); // R8
  AST_PROG_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog |-> wen); // R5
  AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog |-> !busy); // R7
  AST_BUSY_FROM_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(prog)); // R7
endmodule

bind mw_eeprom_slave mw_eeprom_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .busy(busy), .prog(prog),
  .wen(wen), .do_o(do_o), .do_oe_o(do_oe_o)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_T     = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, doe;
  int   nchk = 0, nfail = 0;
  logic [7:0] mem_m [128];
  logic wen_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_slave #(.WORD_AW(6), .BUSY_CYCLES(BUSY_T), .SYNC_STAGES(2)) i_mw_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org_i(org), .do_o(dout), .do_oe_o(doe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b);
    di = b; tick(4); sclk = 1'b1; tick(8); sclk = 1'b0; tick(4);
  endtask

  task automatic sel_off();
    cs = 1'b0; sclk = 1'b0; di = 1'b0; tick(8);
  endtask

  task automatic sel_on();
    cs = 1'b1; tick(8);
  endtask

  function automatic int alen(input logic o); return o ? 6 : 7; endfunction
  function automatic int dlen(input logic o); return o ? 16 : 8; endfunction

  function automatic logic [15:0] exp_word(input logic o, input int a);
    if (o) return {mem_m[2*a], mem_m[2*a+1]};
    return {8'h00, mem_m[a]};
  endfunction

  task automatic send_hdr(input logic [1:0] op, input int a, input logic o);
    org = o;
    bit_io(1'b1);
    bit_io(op[1]); bit_io(op[0]);
    for (int i = alen(o) - 1; i >= 0; i--) bit_io(a[i]);
  endtask

  // R4 / R9 / R2: read and compare against model
  task automatic do_read(input logic o, input int a, input int lead0);
    logic [15:0] got;
    got = '0;
    sel_on();
    for (int i = 0; i < lead0; i++) bit_io(1'b0);
    send_hdr(2'b10, a, o);
    chk("R4 dummy bit", {doe, dout}, 2'b10);
    for (int i = 0; i < dlen(o); i++) begin
      bit_io(1'b0);
      got = {got[14:0], dout};
    end
    if (!o) got = {8'h00, got[7:0]};
    chk("R4 read word", got, exp_word(o, a));
    bit_io(1'b1);
    chk("R4 release after last bit", doe, 1'b0);
    bit_io(1'b1); bit_io(1'b0);
    chk("R9 ignored after read", doe, 1'b0);
    sel_off();
  endtask

  task automatic model_prog(input logic o, input int a, input logic [15:0] d);
    if (o) begin mem_m[2*a] = d[15:8]; mem_m[2*a+1] = d[7:0]; end
    else mem_m[a] = d[7:0];
  endtask

  task automatic finish_prog(input logic o, input int a, input logic [15:0] d, input string tag);
    sel_off(); sel_on();
    if (wen_m) begin
      chk({tag, " R8 busy flag"}, {doe, dout}, 2'b10);
      tick(BUSY_T + 10);
      chk({tag, " R8 ready flag"}, {doe, dout}, 2'b11);
      model_prog(o, a, d);
    end else begin
      chk({tag, " R5 locked no busy"}, doe, 1'b0);
    end
    sel_off();
    chk("R1 deselect releases", doe, 1'b0);
  endtask

  task automatic do_write(input logic o, input int a, input logic [15:0] d);
    sel_on();
    send_hdr(2'b01, a, o);
    for (int i = dlen(o) - 1; i >= 0; i--) bit_io(d[i]);
    finish_prog(o, a, d, "write");
  endtask

  task automatic do_erase(input logic o, input int a);
    sel_on();
    send_hdr(2'b11, a, o);
    finish_prog(o, a, 16'hFFFF, "R6 erase");
  endtask

  task automatic do_ext(input logic en);
    int a;
    a = en ? (3 << (alen(org) - 2)) : 0;
    sel_on();
    send_hdr(2'b00, a, org);
    sel_off();
    wen_m = en;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = 8'hxx;
    tick(5); rst_n = 1'b1; tick(3);
    chk("R11 reset output disabled", doe, 1'b0);

    // R5/R11: writes locked after reset
    do_write(1'b1, 3, 16'h1234);
    do_ext(1'b1);                      // R3 extended enable
    do_write(1'b1, 3, 16'hBEEF);
    do_ext(1'b0);                      // R3 extended disable
    do_write(1'b1, 3, 16'h1234);
    do_read(1'b1, 3, 0);               // R5 still BEEF
    do_ext(1'b1);

    // R10: shared byte order
    do_write(1'b1, 5, 16'hA55A);
    do_read(1'b0, 10, 0);
    do_read(1'b0, 11, 0);
    do_write(1'b0, 10, 16'h003C);
    do_read(1'b1, 5, 0);               // R10 expect 3C5A

    // R6: erase in both modes
    do_erase(1'b0, 11);
    do_read(1'b1, 5, 0);
    do_erase(1'b1, 5);
    do_read(1'b1, 5, 0);

    // R2: leading zero clocks before start bit
    do_read(1'b1, 3, 5);

    // R8: select held high through programming keeps output disabled
    sel_on();
    send_hdr(2'b01, 7, 1'b1);
    for (int i = 15; i >= 0; i--) bit_io(logic'((16'h0F0F >> i) & 1));
    chk("R8 held select no flag", doe, 1'b0);
    tick(BUSY_T + 10);
    chk("R8 held select no flag after", doe, 1'b0);
    sel_off();
    model_prog(1'b1, 7, 16'h0F0F);
    do_read(1'b1, 7, 0);

    // R7: start bit during busy ignored
    do_write(1'b1, 8, 16'h2222);
    sel_on();
    send_hdr(2'b01, 7, 1'b1);
    for (int i = 15; i >= 0; i--) bit_io(logic'((16'h1111 >> i) & 1));
    sel_off(); sel_on();
    send_hdr(2'b01, 8, 1'b1);
    for (int i = 15; i >= 0; i--) bit_io(logic'((16'h5555 >> i) & 1));
    tick(BUSY_T);
    sel_off();
    model_prog(1'b1, 7, 16'h1111);
    do_read(1'b1, 8, 0);               // R7 expect 2222
    do_read(1'b1, 7, 0);

    // R7: completes with select low and no serial clock
    sel_on();
    send_hdr(2'b01, 9, 1'b1);
    for (int i = 15; i >= 0; i--) bit_io(logic'((16'hC0DE >> i) & 1));
    sel_off();
    tick(BUSY_T + 10);
    sel_on();
    chk("R7 no flag after completion", doe, 1'b0);
    sel_off();
    model_prog(1'b1, 9, 16'hC0DE);
    do_read(1'b1, 9, 0);

    // R1: aborted write frame
    sel_on();
    send_hdr(2'b01, 9, 1'b1);
    for (int i = 0; i < 5; i++) bit_io(1'b1);
    sel_off();
    do_read(1'b1, 9, 0);
    // R1: deselect mid-read
    sel_on();
    send_hdr(2'b10, 9, 1'b1);
    bit_io(1'b0);
    sel_off();
    chk("R1 deselect mid-read", doe, 1'b0);

    // random section on words 16..23 / bytes 32..47
    void'($urandom(32'd4242));
    for (int w = 16; w < 24; w++) do_write(1'b1, w, 16'(w * 16'h0101));
    for (int n = 0; n < 40; n++) begin
      logic o;
      int   k, a;
      o = logic'($urandom_range(0, 1));
      a = o ? $urandom_range(16, 23) : $urandom_range(32, 47);
      k = $urandom_range(0, 9);
      if (k < 4)       do_read(o, a, $urandom_range(0, 2));
      else if (k < 7)  do_write(o, a, 16'($urandom));
      else if (k < 8)  do_erase(o, a);
      else             do_ext(logic'($urandom_range(0, 2) != 0));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule